// File: doc/BRIEF.md
# Shared-Buffer Output-Queued Cell Switch

This block is the core of a small output-queued switch. Each ingress port delivers fixed-size cells one bit per cycle. A per-port shift register gathers the bits of a whole cell. The complete cell is then stored in a shared cell buffer and linked onto the queue of its destination output. The buffer is split into several banks. Each bank stays busy for a configurable number of cycles after every access. Successive cells are placed in the banks either in strict rotation or, in the alternative mode, starting from a bank picked by a pseudo-random sequence. The bank count should exceed the access time in cell writes, so that the rotation only comes back to a bank once its previous write has finished.

An output that is granted takes the oldest cell of its queue out of the buffer and shifts it out one bit per cycle. The storage slot of that cell goes back to the free pool of its bank. At most one cell is stored and one cell is fetched per clock. Because a cell needs many cycles to assemble, this rate covers every port within one cell time. When no slot is left anywhere, arriving cells are discarded and counted per ingress port.

Top module: `swq_switch`

## Requirements
- R1: After reset, out_vld_o, buf_full_o and bank_err_o are 0 and every drop counter reads 0.
- R2: A cell is received most significant bit first while in_vld_i is high. The destination on in_dst_i is taken in the cycle that carries the last bit. The cell leaves unchanged on that output: out_vld_o is high for CELL_BITS consecutive cycles and out_bit_o carries the bits most significant first.
- R3: Cells bound for the same output leave in the order in which they were stored.
- R4: An output starts a new cell only while its out_grant_i is high. With the grant low, the queued cells are held and are sent once the grant returns.
- R5: Cells that complete in the same cycle on all ingress ports are all stored and delivered.
- R6: A bank is never accessed again, by either a store or a fetch, until BANK_LAT cycles after its previous access. With rotation and more banks than BANK_LAT, cell stores never find their bank busy.
- R7: When the chosen bank is still busy from an earlier store (rotation mode), or all banks with free slots are busy and at least one of them is busy from a store (random mode), the store waits with the cell kept. bank_err_o is set and stays set until reset.
- R8: In random mode (BANK_SEL = BSEL_LFSR), the search for a bank starts at the low bits of a 16-bit LFSR and moves upward. It takes the first bank that is neither busy nor out of slots. All cells are still delivered.
- R9: buf_full_o is high while no bank has a free slot. An arriving cell that finds the buffer full is dropped, and the drop counter of its ingress port, field p of drop_cnt_o, rises by one. A cell that completes while its port still holds an unstored cell is also dropped and counted.
- R10: A slot freed by a fetch can be used again. After the queues drain, buf_full_o returns to 0 and new cells are stored and delivered. The queued cells plus the free slots always equal the buffer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | N_PORTS | Per ingress port: a cell bit is present |
| in_bit_i | input | N_PORTS | Per ingress port: serial cell bit |
| in_dst_i | input | N_PORTS*PW | Per ingress port: destination output, sampled with the last bit |
| out_grant_i | input | N_PORTS | Per output: permission to start a cell |
| out_vld_o | output | N_PORTS | Per output: a cell bit is present |
| out_bit_o | output | N_PORTS | Per output: serial cell bit |
| buf_full_o | output | 1 | No free slot in any bank |
| bank_err_o | output | 1 | Sticky: a store found its bank busy from a store |
| drop_cnt_o | output | N_PORTS*DROP_W | Per ingress port: count of dropped cells |

## Verification
The bench builds two copies with 4 ports and 32-bit cells. The first uses rotation over 4 banks of 4 slots with a 3-cycle access time, which meets the sizing rule. With it, the bench checks that simultaneous arrivals never cause a bank error and that all 16 slots can be filled so that the 17th cell is dropped. The second uses random placement over only 2 banks with a 6-cycle access time. Four cells that complete together on all ports therefore force a store to wait and set the error flag. Its 8-slot buffer fills after 8 cells, so the same stream produces nine drops. Both copies get the same traffic, and a queue model in the bench predicts delivery order and drop counts for each of them.

// File: rtl/swq_pkg.sv
package swq_pkg;
  typedef enum logic {BSEL_ROTATE = 1'b0, BSEL_LFSR = 1'b1} bank_sel_e;

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/swq_ingress.sv
module swq_ingress #(
  parameter int CELL_BITS = 32,
  parameter int PW        = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 bit_i,
  input  logic [PW-1:0]        dst_i,
  input  logic                 take_i,
  output logic                 pend_o,
  output logic [CELL_BITS-1:0] data_o,
  output logic [PW-1:0]        dst_o,
  output logic                 overrun_o
);
  localparam int CW = $clog2(CELL_BITS);

  logic [CW-1:0]        cnt_q;
  logic [CELL_BITS-1:0] sr_q;
  logic [CELL_BITS-1:0] cell_w;
  logic                 done;

  assign done      = vld_i && (cnt_q == CW'(CELL_BITS - 1));
  assign cell_w    = {sr_q[CELL_BITS-2:0], bit_i};
  assign overrun_o = done && pend_o && !take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      pend_o <= 1'b0;
      data_o <= '0;
      dst_o  <= '0;
    end else begin
      if (vld_i) begin
        sr_q  <= cell_w;
        cnt_q <= done ? '0 : cnt_q + 1'b1;
      end
      if (done && (!pend_o || take_i)) begin
        pend_o <= 1'b1;
        data_o <= cell_w;
        dst_o  <= dst_i;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swq_bank_alloc.sv
module swq_bank_alloc
  import swq_pkg::*;
#(
  parameter int        N_BANKS  = 4,
  parameter int        DEPTH    = 4,
  parameter int        LAT      = 3,
  parameter bank_sel_e BANK_SEL = BSEL_ROTATE,
  localparam int       BW       = $clog2(N_BANKS),
  localparam int       SW       = $clog2(DEPTH),
  localparam int       FC_W     = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      rd_i,
  input  logic [BW-1:0]             rd_bank_i,
  input  logic [SW-1:0]             free_slot_i,
  output logic                      gnt_o,
  output logic [BW-1:0]             bank_o,
  output logic [SW-1:0]             slot_o,
  output logic                      full_o,
  output logic [N_BANKS-1:0]        busy_o,
  output logic                      err_o,
  output logic [N_BANKS*FC_W-1:0]   free_cnt_o
);
  localparam int LC_W = $clog2(LAT + 1);

  logic [N_BANKS-1:0] empty, wbusy;
  logic [SW-1:0]      head_slot [N_BANKS];
  logic [BW-1:0]      rot_q;
  logic [15:0]        lfsr_q;
  logic               stall_err, adv_rot;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [SW-1:0]   fl_q [DEPTH];
    logic [SW-1:0]   rp_q, wp_q;
    logic [FC_W-1:0] fc_q;
    logic [LC_W-1:0] bc_q;
    logic            wf_q;
    logic            pop, push;

    assign pop  = gnt_o && (bank_o == BW'(b));
    assign push = rd_i && (rd_bank_i == BW'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) fl_q[i] <= SW'(i);
        rp_q <= '0;
        wp_q <= '0;
        fc_q <= FC_W'(DEPTH);
        bc_q <= '0;
        wf_q <= 1'b0;
      end else begin
        if (push) begin
          fl_q[wp_q] <= free_slot_i;
          wp_q       <= wp_q + 1'b1;
        end
        if (pop) rp_q <= rp_q + 1'b1;
        fc_q <= fc_q + FC_W'(push) - FC_W'(pop);
        if (pop || push) begin
          bc_q <= LC_W'(LAT - 1);
          wf_q <= pop;
        end else if (bc_q != '0) begin
          bc_q <= bc_q - 1'b1;
        end
      end
    end

    assign empty[b]     = (fc_q == '0);
    assign busy_o[b]    = (bc_q != '0);
    assign wbusy[b]     = busy_o[b] && wf_q;
    assign head_slot[b] = fl_q[rp_q];
    assign free_cnt_o[b*FC_W +: FC_W] = fc_q;
  end

  assign full_o = &empty;
  assign slot_o = head_slot[bank_o];

  always_comb begin
    gnt_o     = 1'b0;
    bank_o    = rot_q;
    stall_err = 1'b0;
    adv_rot   = 1'b0;
    if (BANK_SEL == BSEL_ROTATE) begin
      if (req_i && !full_o) begin
        if (busy_o[rot_q]) stall_err = wbusy[rot_q];
        else if (empty[rot_q]) adv_rot = 1'b1;  // skip exhausted bank
        else begin
          gnt_o   = 1'b1;
          adv_rot = 1'b1;
        end
      end
    end else begin
      logic          found;
      logic [BW-1:0] cand;
      found = 1'b0;
      for (int k = 0; k < N_BANKS; k++) begin
        cand = lfsr_q[BW-1:0] + BW'(k);
        if (!found && !busy_o[cand] && !empty[cand]) begin
          found  = 1'b1;
          bank_o = cand;
        end
      end
      if (req_i && !full_o) begin
        if (found) gnt_o = 1'b1;
        else stall_err = |wbusy;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rot_q  <= '0;
      lfsr_q <= 16'hACE1;
      err_o  <= 1'b0;
    end else begin
      lfsr_q <= lfsr_step(lfsr_q);
      if (adv_rot) rot_q <= rot_q + 1'b1;
      if (stall_err) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/swq_egress.sv
module swq_egress #(
  parameter int CELL_BITS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CELL_BITS-1:0] data_i,
  output logic                 ready_o,
  output logic                 vld_o,
  output logic                 bit_o
);
  localparam int CW = $clog2(CELL_BITS + 1);

  logic [CW-1:0]        cnt_q;
  logic [CELL_BITS-1:0] sr_q;

  assign vld_o   = (cnt_q != '0);
  assign bit_o   = sr_q[CELL_BITS-1];
  assign ready_o = (cnt_q <= CW'(1));  // allows back-to-back cells

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (load_i) begin
      cnt_q <= CW'(CELL_BITS);
      sr_q  <= data_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      sr_q  <= {sr_q[CELL_BITS-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/swq_switch.sv
module swq_switch
  import swq_pkg::*;
#(
  parameter int        N_PORTS    = 4,
  parameter int        CELL_BITS  = 32,
  parameter int        N_BANKS    = 4,
  parameter int        BANK_DEPTH = 4,
  parameter int        BANK_LAT   = 3,
  parameter bank_sel_e BANK_SEL   = BSEL_ROTATE,
  parameter int        DROP_W     = 8,
  localparam int       PW         = $clog2(N_PORTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          in_vld_i,
  input  logic [N_PORTS-1:0]          in_bit_i,
  input  logic [N_PORTS*PW-1:0]       in_dst_i,
  input  logic [N_PORTS-1:0]          out_grant_i,
  output logic [N_PORTS-1:0]          out_vld_o,
  output logic [N_PORTS-1:0]          out_bit_o,
  output logic                        buf_full_o,
  output logic                        bank_err_o,
  output logic [N_PORTS*DROP_W-1:0]   drop_cnt_o
);
  localparam int BW      = $clog2(N_BANKS);
  localparam int SW      = $clog2(BANK_DEPTH);
  localparam int AW      = BW + SW;
  localparam int N_CELLS = N_BANKS * BANK_DEPTH;
  localparam int QC_W    = $clog2(N_CELLS + 1);
  localparam int FC_W    = $clog2(BANK_DEPTH + 1);

  logic [N_PORTS-1:0]   pend, overrun, take, eg_ready, eg_load;
  logic [CELL_BITS-1:0] pdata [N_PORTS];
  logic [PW-1:0]        pdst  [N_PORTS];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_in
    swq_ingress #(.CELL_BITS(CELL_BITS), .PW(PW)) u_in (
      .clk_i, .rst_ni,
      .vld_i(in_vld_i[p]), .bit_i(in_bit_i[p]), .dst_i(in_dst_i[p*PW +: PW]),
      .take_i(take[p]), .pend_o(pend[p]), .data_o(pdata[p]), .dst_o(pdst[p]),
      .overrun_o(overrun[p])
    );
  end

  // enqueue side: one pending ingress cell per cycle, round robin
  logic          sel_vld;
  logic [PW-1:0] rr_q, sel_port;

  always_comb begin
    sel_vld  = 1'b0;
    sel_port = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      int idx;
      idx = (int'(rr_q) + k) % N_PORTS;
      if (!sel_vld && pend[idx]) begin
        sel_vld  = 1'b1;
        sel_port = PW'(idx);
      end
    end
  end

  logic                    wr_fire, drop_full;
  logic [BW-1:0]           wr_bank;
  logic [SW-1:0]           wr_slot;
  logic [AW-1:0]           wr_addr;
  logic [PW-1:0]           wr_dst;
  logic [N_BANKS-1:0]      bank_busy;
  logic [N_BANKS*FC_W-1:0] free_cnt;
  logic                    rd_fire;
  logic [PW-1:0]           rd_port, orr_q;
  logic [AW-1:0]           rd_addr;
  logic [BW-1:0]           rd_bank;

  assign drop_full = sel_vld && buf_full_o;
  assign wr_addr   = {wr_bank, wr_slot};
  assign wr_dst    = pdst[sel_port];
  assign rd_bank   = rd_addr[AW-1:SW];

  always_comb begin
    take = '0;
    take[sel_port] = wr_fire || drop_full;
  end

  swq_bank_alloc #(
    .N_BANKS(N_BANKS), .DEPTH(BANK_DEPTH), .LAT(BANK_LAT), .BANK_SEL(BANK_SEL)
  ) u_alloc (
    .clk_i, .rst_ni,
    .req_i(sel_vld), .rd_i(rd_fire), .rd_bank_i(rd_bank), .free_slot_i(rd_addr[SW-1:0]),
    .gnt_o(wr_fire), .bank_o(wr_bank), .slot_o(wr_slot), .full_o(buf_full_o),
    .busy_o(bank_busy), .err_o(bank_err_o), .free_cnt_o(free_cnt)
  );

  // cell storage and per-output linked lists
  logic [CELL_BITS-1:0] mem_q  [N_CELLS];
  logic [AW-1:0]        nxt_q  [N_CELLS];
  logic [AW-1:0]        head_q [N_PORTS];
  logic [AW-1:0]        tail_q [N_PORTS];
  logic [QC_W-1:0]      qcnt_q [N_PORTS];
  logic [N_PORTS*QC_W-1:0] qcnt_flat;

  for (genvar o = 0; o < N_PORTS; o++) begin : g_qf
    assign qcnt_flat[o*QC_W +: QC_W] = qcnt_q[o];
  end

  always_ff @(posedge clk_i) begin
    if (wr_fire) begin
      mem_q[wr_addr] <= pdata[sel_port];
      if (qcnt_q[wr_dst] != '0) nxt_q[tail_q[wr_dst]] <= wr_addr;
    end
  end

  // dequeue side: one granted output per cycle, round robin
  always_comb begin
    rd_fire = 1'b0;
    rd_port = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      int            idx;
      logic [BW-1:0] hb;
      idx = (int'(orr_q) + k) % N_PORTS;
      hb  = head_q[idx][AW-1:SW];
      if (!rd_fire && out_grant_i[idx] && eg_ready[idx] && qcnt_q[idx] != '0 &&
          !bank_busy[hb] && !(wr_fire && wr_bank == hb)) begin
        rd_fire = 1'b1;
        rd_port = PW'(idx);
      end
    end
  end

  assign rd_addr = head_q[rd_port];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int o = 0; o < N_PORTS; o++) begin
        head_q[o] <= '0;
        tail_q[o] <= '0;
        qcnt_q[o] <= '0;
      end
      rr_q  <= '0;
      orr_q <= '0;
    end else begin
      for (int o = 0; o < N_PORTS; o++) begin
        logic enq, deq;
        enq = wr_fire && (wr_dst == PW'(o));
        deq = rd_fire && (rd_port == PW'(o));
        if (deq) head_q[o] <= (qcnt_q[o] == QC_W'(1) && enq) ? wr_addr : nxt_q[head_q[o]];
        else if (enq && qcnt_q[o] == '0) head_q[o] <= wr_addr;
        if (enq) tail_q[o] <= wr_addr;
        qcnt_q[o] <= qcnt_q[o] + QC_W'(enq) - QC_W'(deq);
      end
      if (wr_fire || drop_full) rr_q <= PW'((int'(sel_port) + 1) % N_PORTS);
      if (rd_fire) orr_q <= PW'((int'(rd_port) + 1) % N_PORTS);
    end
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_drop
    logic [DROP_W-1:0] dc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dc_q <= '0;
      else if (overrun[p] || (drop_full && sel_port == PW'(p))) dc_q <= dc_q + 1'b1;
    end
    assign drop_cnt_o[p*DROP_W +: DROP_W] = dc_q;
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    assign eg_load[o] = rd_fire && (rd_port == PW'(o));
    swq_egress #(.CELL_BITS(CELL_BITS)) u_eg (
      .clk_i, .rst_ni, .load_i(eg_load[o]), .data_i(mem_q[rd_addr]),
      .ready_o(eg_ready[o]), .vld_o(out_vld_o[o]), .bit_o(out_bit_o[o])
    );
  end
endmodule

// File: rtl/swq_checker.sv
module swq_checker #(
  parameter int N_PORTS    = 4,
  parameter int N_BANKS    = 4,
  parameter int BANK_DEPTH = 4,
  parameter int BANK_LAT   = 3,
  parameter int DROP_W     = 8,
  localparam int BW        = $clog2(N_BANKS),
  localparam int N_CELLS   = N_BANKS * BANK_DEPTH,
  localparam int QC_W      = $clog2(N_CELLS + 1),
  localparam int FC_W      = $clog2(BANK_DEPTH + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_PORTS-1:0]          out_grant_i,
  input logic [N_PORTS-1:0]          out_vld_o,
  input logic                        buf_full_o,
  input logic                        bank_err_o,
  input logic [N_PORTS*DROP_W-1:0]   drop_cnt_o,
  input logic                        wr_fire,
  input logic [BW-1:0]               wr_bank,
  input logic                        rd_fire,
  input logic [BW-1:0]               rd_bank,
  input logic [N_PORTS*QC_W-1:0]     qcnt_flat,
  input logic [N_BANKS*FC_W-1:0]     free_cnt
);
  localparam int GW = $clog2(BANK_LAT + 1) + 1;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_gap
    logic          acc;
    logic [GW-1:0] since_q;
    assign acc = (wr_fire && wr_bank == BW'(b)) || (rd_fire && rd_bank == BW'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) since_q <= GW'(BANK_LAT);
      else if (acc) since_q <= GW'(1);
      else if (since_q < GW'(BANK_LAT)) since_q <= since_q + 1'b1;
    end
    // R6
    bank_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc |-> since_q >= GW'(BANK_LAT));
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_gate
    // R4
    grant_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!out_grant_i[o] && !out_vld_o[o]) |=> !out_vld_o[o]);
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_dc
    // R9
    drop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ##1 (drop_cnt_o[p*DROP_W +: DROP_W] == $past(drop_cnt_o[p*DROP_W +: DROP_W]) ||
           drop_cnt_o[p*DROP_W +: DROP_W] == DROP_W'($past(drop_cnt_o[p*DROP_W +: DROP_W]) + 1'b1)));
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_err_o |=> bank_err_o);

  // R9
  full_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_o |-> !wr_fire);

  int unsigned tot;
  always_comb begin
    tot = 0;
    for (int o = 0; o < N_PORTS; o++) tot += 32'(qcnt_flat[o*QC_W +: QC_W]);
    for (int b = 0; b < N_BANKS; b++) tot += 32'(free_cnt[b*FC_W +: FC_W]);
  end

  // R10
  slot_conserve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tot == N_CELLS);
endmodule

bind swq_switch swq_checker #(
  .N_PORTS(N_PORTS), .N_BANKS(N_BANKS), .BANK_DEPTH(BANK_DEPTH),
  .BANK_LAT(BANK_LAT), .DROP_W(DROP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .out_grant_i(out_grant_i), .out_vld_o(out_vld_o),
  .buf_full_o(buf_full_o), .bank_err_o(bank_err_o), .drop_cnt_o(drop_cnt_o),
  .wr_fire(wr_fire), .wr_bank(wr_bank), .rd_fire(rd_fire), .rd_bank(rd_bank),
  .qcnt_flat(qcnt_flat), .free_cnt(free_cnt)
);

// File: tb/tb_swq_switch.sv
module tb_swq_switch;
  import swq_pkg::*;

  localparam int NP = 4;
  localparam int CB = 32;
  localparam int PW = 2;
  localparam int DW = 8;
  localparam int CAP0 = 16;
  localparam int CAP1 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0]    in_vld = '0, in_bit = '0, grant = '0;
  logic [NP*PW-1:0] in_dst = '0;
  logic [NP-1:0]    vld0, bit0, vld1, bit1;
  logic             full0, full1, err0, err1;
  logic [NP*DW-1:0] dc0, dc1;

  swq_switch dut (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_bit_i(in_bit), .in_dst_i(in_dst),
    .out_grant_i(grant), .out_vld_o(vld0), .out_bit_o(bit0), .buf_full_o(full0),
    .bank_err_o(err0), .drop_cnt_o(dc0)
  );

  swq_switch #(.N_BANKS(2), .BANK_DEPTH(4), .BANK_LAT(6), .BANK_SEL(BSEL_LFSR)) dut_r (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_bit_i(in_bit), .in_dst_i(in_dst),
    .out_grant_i(grant), .out_vld_o(vld1), .out_bit_o(bit1), .buf_full_o(full1),
    .bank_err_o(err1), .drop_cnt_o(dc1)
  );

  int total = 0, bad = 0, mon_total = 0, mon_bad = 0;
  int occ0 = 0, occ1 = 0, cyc = 0;
  int drops0 [NP];
  int drops1 [NP];
  int rxn0 [NP];
  int rxn1 [NP];
  logic [CB-1:0] exp0 [NP][$];
  logic [CB-1:0] exp1 [NP][$];
  logic [CB-1:0] rx0 [NP];
  logic [CB-1:0] rx1 [NP];
  int rc0 [NP];
  int rc1 [NP];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  // output monitors: rebuild cells MSB first and compare with the model (R2, R3)
  always @(negedge clk) begin
    for (int o = 0; o < NP; o++) begin
      if (vld0[o]) begin
        rx0[o] = {rx0[o][CB-2:0], bit0[o]};
        rc0[o]++;
        if (rc0[o] == CB) begin
          rc0[o] = 0;
          mon_total++;
          rxn0[o]++;
          occ0--;
          if (exp0[o].size() == 0) begin
            mon_bad++;
            $display("FAIL R3 dut out%0d unexpected cell actual=%0h expected=%0d", o, rx0[o], 0);
          end else begin
            logic [CB-1:0] e;
            e = exp0[o].pop_front();
            if (rx0[o] != e) begin
              mon_bad++;
              $display("FAIL R2 dut out%0d actual=%0h expected=%0h", o, rx0[o], e);
            end
          end
        end
      end
      if (vld1[o]) begin
        rx1[o] = {rx1[o][CB-2:0], bit1[o]};
        rc1[o]++;
        if (rc1[o] == CB) begin
          rc1[o] = 0;
          mon_total++;
          rxn1[o]++;
          occ1--;
          if (exp1[o].size() == 0) begin
            mon_bad++;
            $display("FAIL R3 dut_r out%0d unexpected cell actual=%0h expected=%0d", o, rx1[o], 0);
          end else begin
            logic [CB-1:0] e;
            e = exp1[o].pop_front();
            if (rx1[o] != e) begin
              mon_bad++;
              $display("FAIL R2 dut_r out%0d actual=%0h expected=%0h", o, rx1[o], e);
            end
          end
        end
      end
    end
  end

  task automatic model_cell(input int p, input int d, input logic [CB-1:0] c);
    if (occ0 < CAP0) begin exp0[d].push_back(c); occ0++; end
    else drops0[p]++;
    if (occ1 < CAP1) begin exp1[d].push_back(c); occ1++; end
    else drops1[p]++;
  endtask

  task automatic send_cells(input logic [NP-1:0] mask, input logic [NP*CB-1:0] dat,
                            input logic [NP*PW-1:0] dst);
    for (int i = 0; i < CB; i++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        in_vld[p] = mask[p];
        in_bit[p] = dat[p*CB + CB - 1 - i];
      end
      in_dst = (i == CB - 1) ? dst : '0;
    end
    @(negedge clk);
    in_vld = '0;
    in_bit = '0;
    for (int p = 0; p < NP; p++)
      if (mask[p]) model_cell(p, int'(dst[p*PW +: PW]), dat[p*CB +: CB]);
  endtask

  task automatic send_one(input int p, input int d, input logic [CB-1:0] c);
    logic [NP*CB-1:0] dat;
    logic [NP*PW-1:0] dst;
    dat = '0;
    dst = '0;
    dat[p*CB +: CB] = c;
    dst[p*PW +: PW] = PW'(d);
    send_cells(NP'(1) << p, dat, dst);
  endtask

  task automatic drain(input string tag);
    int n0, n1, w;
    w = 0;
    do begin
      @(negedge clk);
      n0 = 0; n1 = 0;
      for (int o = 0; o < NP; o++) begin
        n0 += exp0[o].size();
        n1 += exp1[o].size();
      end
      w++;
    end while ((n0 != 0 || n1 != 0) && w < 4000);
    check(n0 == 0, {tag, " dut cells outstanding"}, n0, 0);
    check(n1 == 0, {tag, " dut_r cells outstanding"}, n1, 0);
  endtask

  task automatic t_reset();
    check(vld0 == '0 && vld1 == '0, "R1 out_vld after reset", int'({vld1, vld0}), 0);
    check(!full0 && !full1, "R1 buf_full after reset", int'({full1, full0}), 0);
    check(!err0 && !err1, "R1 bank_err after reset", int'({err1, err0}), 0);
    check(dc0 == '0 && dc1 == '0, "R1 drop counters after reset", int'(dc0 | dc1), 0);
  endtask

  task automatic t_basic();
    grant = '1;
    send_one(1, 2, 32'hA5C3_0F96);
    send_one(3, 0, 32'h8000_0001);
    drain("R2");
    check(rxn0[2] == 1 && rxn0[0] == 1, "R2 dut cells on destination", rxn0[2] + rxn0[0], 2);
  endtask

  task automatic t_order();
    int b0;
    b0 = rxn0[3];
    grant = '1;
    send_one(0, 3, 32'h1111_0001);
    send_one(0, 3, 32'h2222_0002);
    send_one(0, 3, 32'h3333_0003);
    drain("R3");
    check(rxn0[3] - b0 == 3, "R3 three ordered cells on out3", rxn0[3] - b0, 3);
  endtask

  task automatic t_grant();
    int b0, b1;
    grant = 4'b1101;
    b0 = rxn0[1];
    b1 = rxn1[1];
    send_one(2, 1, 32'hDEAD_BEEF);
    repeat (150) @(negedge clk);
    check(rxn0[1] == b0 && rc0[1] == 0, "R4 dut held without grant", rc0[1], 0);
    check(rxn1[1] == b1 && rc1[1] == 0, "R4 dut_r held without grant", rc1[1], 0);
    grant = '1;
    drain("R4");
    check(rxn0[1] == b0 + 1, "R4 dut sent after grant", rxn0[1] - b0, 1);
  endtask

  task automatic t_concurrent();
    grant = '1;
    send_cells(4'b1111,
               {32'h4444_AAAA, 32'h3333_5555, 32'h2222_CCCC, 32'h1111_3333},
               {2'd0, 2'd3, 2'd2, 2'd1});
    drain("R5");
    check(!err0, "R6 rotation with enough banks has no bank error", int'(err0), 0);
    check(err1, "R7 undersized banks set bank error", int'(err1), 1);
    check(occ1 == 0, "R8 random mode delivered all cells", occ1, 0);
    repeat (10) @(negedge clk);
    check(err1, "R7 bank error stays set", int'(err1), 1);
  endtask

  task automatic t_full();
    grant = 4'b1110;
    for (int i = 0; i < 17; i++) send_one(0, 0, 32'hC000_0000 | 32'(i));
    repeat (10) @(negedge clk);
    check(full0, "R9 dut full after 16 cells", int'(full0), 1);
    check(full1, "R9 dut_r full after 8 cells", int'(full1), 1);
    check(int'(dc0[0 +: DW]) == drops0[0], "R9 dut port0 drops", int'(dc0[0 +: DW]), drops0[0]);
    check(int'(dc1[0 +: DW]) == drops1[0], "R9 dut_r port0 drops", int'(dc1[0 +: DW]), drops1[0]);
    check(drops0[0] == 1 && drops1[0] == 9, "R9 model drop totals", drops0[0] + drops1[0], 10);
    check(dc0[DW +: DW] == '0, "R9 other port no drops", int'(dc0[DW +: DW]), 0);
    grant = '1;
    drain("R10");
    check(!full0 && !full1, "R10 full clears after drain", int'({full1, full0}), 0);
    send_one(2, 0, 32'h0BAD_F00D);
    drain("R10");
    check(int'(dc0[0 +: DW]) == 1, "R10 no further drops after reuse", int'(dc0[0 +: DW]), 1);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      drops0[i] = 0; drops1[i] = 0; rxn0[i] = 0; rxn1[i] = 0;
      rx0[i] = '0; rx1[i] = '0; rc0[i] = 0; rc1[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_grant();
    t_concurrent();
    t_full();
    summary();
  end
endmodule